// File: doc/BRIEF.md
# DMA Transfer Register File

This block holds the two working counters of a DMA block-transfer adapter and presents them, together with a status word and a control word, to a host on a shared 16-bit active-low data bus. The transfer address register is loaded from the bus and steps upward once per word moved. The block length register is loaded from the bus with the word count and steps downward once per word. When it reaches zero, the block raises a completion flag in both polarities so that the sequencing logic knows the whole block has been moved.

Both counters are built from 4-bit stages clocked together. The lowest stage always steps. Each higher stage steps only when every stage below it sits at its limit: zero for the length counter, all ones for the address counter. A two-bit read select chooses the word that goes onto the bus. The bus is driven through two driver groups with separate enables. One group covers bits 0, 1, 6 and 7. The other covers the remaining twelve bits. Status and control reads enable only the first group, and every bit that is not driven is left at high impedance.

Top module: `dma_xfer_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears the length and address counters to 0 at the next clock edge. While `rd_en` is low, both `drv_lo` and `drv_hi` are low.
- R2: When `len_load` is high at a clock edge, the length counter takes the bitwise inverse of `data_n`. The bus lines are active-low.
- R3: When `len_dec` is high at a clock edge and the length counter is not zero, it takes its previous value minus one. A borrow crosses into stage k (bits 4k+3..4k) only when every lower stage was zero.
- R4: When `len_dec` arrives while the length counter is already zero, the counter stays at zero.
- R5: `len_zero` is high exactly when the length counter is zero, and `len_zero_n` is always its complement.
- R6: `adr_load` loads the address counter with the inverse of `data_n`. When `adr_inc` is high, the address counter adds one, with a carry into stage k only when all lower stages were 0xF. It wraps from 0xFFFF to 0x0000.
- R7: A load and a step on the same counter in the same cycle result in the loaded value.
- R8: `rd_sel` is decoded with bit 0 as the low address line and bit 1 as the high line: 00 selects status, 11 selects control, 10 selects length and 01 selects address. When `rd_en` is high, `drv_lo` is high for every select, and `drv_hi` is high only for the length and address selects.
- R9: The status word has `chain_flag` at bit 7, `abort_flag` at bit 6, a constant 1 at bit 1 and a 0 at bit 0. On `bus_n` it appears inverted.
- R10: The control word has `busabort_flag` at bit 7, a constant 1 at bit 6, `mode_flag` at bit 1 and a constant 1 at bit 0. On `bus_n` it appears inverted.
- R11: A length or address read drives all 16 bits of `bus_n` with the inverse of the selected counter.
- R12: During a status or control read, bits 2 to 5 and 8 to 15 of `bus_n` are high-impedance and `drv_hi` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_n | input | 16 | Active-low bus data used for counter loads |
| len_load | input | 1 | Load length counter from `data_n` |
| len_dec | input | 1 | Decrement length counter by one word |
| adr_load | input | 1 | Load address counter from `data_n` |
| adr_inc | input | 1 | Increment address counter |
| rd_en | input | 1 | Host read of the selected word |
| rd_sel | input | 2 | Word select: 00 status, 11 control, 10 length, 01 address |
| chain_flag | input | 1 | Status source for bit 7 |
| abort_flag | input | 1 | Status source for bit 6 |
| busabort_flag | input | 1 | Control source for bit 7 |
| mode_flag | input | 1 | Control source for bit 1 |
| bus_n | output | 16 | Active-low readback onto the bus, high-impedance where not driven |
| drv_lo | output | 1 | Driver enable for bits 0, 1, 6 and 7 |
| drv_hi | output | 1 | Driver enable for the other twelve bits |
| len_zero | output | 1 | Length counter is zero (active high) |
| len_zero_n | output | 1 | Length counter is zero (active low) |

## Verification
The assertions assume `rst` is high at the first clock edge. They also assume that all control inputs and `rd_sel` are settled, with no X values, at every edge after reset. The stimulus holds `rst` from time zero, changes every input only on the falling clock edge, and returns every strobe to zero between operations. The assertions allow a load and a step to arrive together. The stimulus exercises that case deliberately, along with decrement at zero and address wrap, so these corner cases are covered within the assumed input envelope.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    // Read select, bit 0 is the low address line, bit 1 the high one.
    typedef enum logic [1:0] {
        SEL_STATUS = 2'b00,
        SEL_ADDR   = 2'b01,
        SEL_LEN    = 2'b10,
        SEL_CTRL   = 2'b11
    } rd_sel_e;

    // Bit positions shared by the status and control words.
    localparam int BIT_HI_FLAG  = 7;
    localparam int BIT_MID_FLAG = 6;
    localparam int BIT_ONE      = 1;
    localparam int BIT_ZERO     = 0;

    // Lanes served by the low driver group.
    localparam logic [7:0] LO_LANES = 8'hC3;

endpackage

// File: rtl/dma_cascade_counter.sv
module dma_cascade_counter #(
    parameter int STAGE_W      = 4,
    parameter int STAGES       = 4,
    parameter bit COUNT_UP     = 1'b0,
    parameter bit HOLD_AT_ZERO = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [STAGE_W*STAGES-1:0]  load_val,
    input  logic                       step,
    output logic [STAGE_W*STAGES-1:0]  value,
    output logic                       all_zero
);
    localparam int W = STAGE_W * STAGES;
    localparam logic [STAGE_W-1:0] LIMIT = COUNT_UP ? {STAGE_W{1'b1}} : {STAGE_W{1'b0}};
    localparam logic [STAGE_W-1:0] ONE   = STAGE_W'(1);

    typedef struct packed {
        logic [STAGES-1:0][STAGE_W-1:0] stg;
    } cnt_s;

    cnt_s st_d, st_q;
    logic [STAGES-1:0] stg_zero;
    logic [STAGES-1:0] lower_at_limit;
    logic              advance;

    // Each stage steps only when all stages beneath it are at the limit.
    assign lower_at_limit[0] = 1'b1;
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_zero
            assign stg_zero[i] = (st_q.stg[i] == '0);
        end
        for (genvar i = 1; i < STAGES; i++) begin : g_chain
            assign lower_at_limit[i] = lower_at_limit[i-1] & (st_q.stg[i-1] == LIMIT);
        end
    endgenerate

    assign all_zero = &stg_zero;
    assign advance  = step & ~(HOLD_AT_ZERO & all_zero);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.stg = load_val;
        end else if (advance) begin
            for (int i = 0; i < STAGES; i++) begin
                if (lower_at_limit[i]) begin
                    st_d.stg[i] = COUNT_UP ? (st_q.stg[i] + ONE) : (st_q.stg[i] - ONE);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign value = W'(st_q.stg);

endmodule

// File: rtl/dma_readback_sel.sv
module dma_readback_sel
    import dmareg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         rd_en,
    input  logic [1:0]   rd_sel,
    input  logic [W-1:0] len_val,
    input  logic [W-1:0] adr_val,
    input  logic         chain_flag,
    input  logic         abort_flag,
    input  logic         busabort_flag,
    input  logic         mode_flag,
    output logic [W-1:0] word,
    output logic         drv_lo,
    output logic         drv_hi
);
    rd_sel_e sel;
    assign sel = rd_sel_e'(rd_sel);

    always_comb begin
        word   = '0;
        drv_lo = 1'b0;
        drv_hi = 1'b0;
        unique case (sel)
            SEL_STATUS: begin
                word[BIT_HI_FLAG]  = chain_flag;
                word[BIT_MID_FLAG] = abort_flag;
                word[BIT_ONE]      = 1'b1;
            end
            SEL_CTRL: begin
                word[BIT_HI_FLAG]  = busabort_flag;
                word[BIT_MID_FLAG] = 1'b1;
                word[BIT_ONE]      = mode_flag;
                word[BIT_ZERO]     = 1'b1;
            end
            SEL_LEN:  word = len_val;
            SEL_ADDR: word = adr_val;
            default:  word = '0;
        endcase
        if (rd_en) begin
            drv_lo = 1'b1;
            drv_hi = (sel == SEL_LEN) || (sel == SEL_ADDR);
        end
    end

endmodule

// File: rtl/dma_xfer_regfile.sv
module dma_xfer_regfile
    import dmareg_pkg::*;
#(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [STAGE_W*STAGES-1:0] data_n,
    input  logic                      len_load,
    input  logic                      len_dec,
    input  logic                      adr_load,
    input  logic                      adr_inc,
    input  logic                      rd_en,
    input  logic [1:0]                rd_sel,
    input  logic                      chain_flag,
    input  logic                      abort_flag,
    input  logic                      busabort_flag,
    input  logic                      mode_flag,
    output logic [STAGE_W*STAGES-1:0] bus_n,
    output logic                      drv_lo,
    output logic                      drv_hi,
    output logic                      len_zero,
    output logic                      len_zero_n
);
    localparam int W = STAGE_W * STAGES;
    localparam logic [W-1:0] LO_MASK = W'(LO_LANES);

    logic [W-1:0] load_word;
    logic [W-1:0] len_val;
    logic [W-1:0] adr_val;
    logic [W-1:0] word;
    logic         len_all_zero;
    logic         adr_all_zero;

    assign load_word = ~data_n;

    dma_cascade_counter #(
        .STAGE_W(STAGE_W), .STAGES(STAGES), .COUNT_UP(1'b0), .HOLD_AT_ZERO(1'b1)
    ) u_len (
        .clk(clk), .rst(rst), .load(len_load), .load_val(load_word),
        .step(len_dec), .value(len_val), .all_zero(len_all_zero)
    );

    dma_cascade_counter #(
        .STAGE_W(STAGE_W), .STAGES(STAGES), .COUNT_UP(1'b1), .HOLD_AT_ZERO(1'b0)
    ) u_adr (
        .clk(clk), .rst(rst), .load(adr_load), .load_val(load_word),
        .step(adr_inc), .value(adr_val), .all_zero(adr_all_zero)
    );

    dma_readback_sel #(.W(W)) u_rd (
        .rd_en(rd_en), .rd_sel(rd_sel), .len_val(len_val), .adr_val(adr_val),
        .chain_flag(chain_flag), .abort_flag(abort_flag),
        .busabort_flag(busabort_flag), .mode_flag(mode_flag),
        .word(word), .drv_lo(drv_lo), .drv_hi(drv_hi)
    );

    assign len_zero   = len_all_zero;
    assign len_zero_n = ~len_all_zero;

    // Per-bit tristate, lane group chosen by the mask.
    generate
        for (genvar i = 0; i < W; i++) begin : g_bus
            if (LO_MASK[i]) begin : g_lo
                assign bus_n[i] = drv_lo ? ~word[i] : 1'bz;
            end else begin : g_hi
                assign bus_n[i] = drv_hi ? ~word[i] : 1'bz;
            end
        end
    endgenerate

    logic unused_adr_zero;
    assign unused_adr_zero = adr_all_zero;

endmodule

// File: rtl/dma_xfer_regfile_chk.sv
module dma_xfer_regfile_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] data_n,
    input logic         len_load,
    input logic         len_dec,
    input logic         adr_load,
    input logic         adr_inc,
    input logic         rd_en,
    input logic [1:0]   rd_sel,
    input logic         chain_flag,
    input logic         busabort_flag,
    input logic [W-1:0] len_val,
    input logic [W-1:0] adr_val,
    input logic [W-1:0] bus_n,
    input logic         drv_lo,
    input logic         drv_hi,
    input logic         len_zero,
    input logic         len_zero_n
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (len_val == '0) && (adr_val == '0));

    a_r1_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> !drv_lo && !drv_hi);

    a_r2_len_load: assert property (@(posedge clk) disable iff (rst)
        len_load |=> len_val == ~$past(data_n));

    a_r3_len_dec: assert property (@(posedge clk) disable iff (rst)
        (len_dec && !len_load && len_val != '0) |=> len_val == $past(len_val) - W'(1));

    a_r4_hold_at_zero: assert property (@(posedge clk) disable iff (rst)
        (len_dec && !len_load && len_val == '0) |=> len_val == '0);

    a_r5_zero_flag: assert property (@(posedge clk) disable iff (rst)
        (len_zero == (len_val == '0)) && (len_zero_n != len_zero));

    a_r6_adr_inc: assert property (@(posedge clk) disable iff (rst)
        (adr_inc && !adr_load) |=> adr_val == $past(adr_val) + W'(1));

    a_r7_adr_load_wins: assert property (@(posedge clk) disable iff (rst)
        adr_load |=> adr_val == ~$past(data_n));

    a_r8_narrow_strobe: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel[0] == rd_sel[1]) |-> drv_lo && !drv_hi);

    a_r8_wide_strobe: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel[0] != rd_sel[1]) |-> drv_lo && drv_hi);

    a_r9_status_bits: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'b00) |-> bus_n[1] == 1'b0 && bus_n[0] == 1'b1 && bus_n[7] == !chain_flag);

    a_r10_control_bits: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'b11) |-> bus_n[0] == 1'b0 && bus_n[6] == 1'b0 && bus_n[7] == !busabort_flag);

    a_r11_len_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == 2'b10) |-> bus_n == ~len_val);

endmodule

bind dma_xfer_regfile dma_xfer_regfile_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .data_n(data_n), .len_load(len_load), .len_dec(len_dec),
    .adr_load(adr_load), .adr_inc(adr_inc), .rd_en(rd_en), .rd_sel(rd_sel),
    .chain_flag(chain_flag), .busabort_flag(busabort_flag),
    .len_val(len_val), .adr_val(adr_val), .bus_n(bus_n), .drv_lo(drv_lo),
    .drv_hi(drv_hi), .len_zero(len_zero), .len_zero_n(len_zero_n)
);

// File: tb/sim_dma_xfer_regfile.sv
`timescale 1ns/1ps
module sim_dma_xfer_regfile;
    localparam logic [15:0] LO_M = 16'h00C3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] data_n = 16'hFFFF;
    logic        len_load = 0, len_dec = 0, adr_load = 0, adr_inc = 0;
    logic        rd_en = 0;
    logic [1:0]  rd_sel = 2'b00;
    logic        chain_flag = 0, abort_flag = 0, busabort_flag = 0, mode_flag = 0;
    wire  [15:0] bus_n;
    logic        drv_lo, drv_hi, len_zero, len_zero_n;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    dma_xfer_regfile u0 (
        .clk(clk), .rst(rst), .data_n(data_n), .len_load(len_load), .len_dec(len_dec),
        .adr_load(adr_load), .adr_inc(adr_inc), .rd_en(rd_en), .rd_sel(rd_sel),
        .chain_flag(chain_flag), .abort_flag(abort_flag), .busabort_flag(busabort_flag),
        .mode_flag(mode_flag), .bus_n(bus_n), .drv_lo(drv_lo), .drv_hi(drv_hi),
        .len_zero(len_zero), .len_zero_n(len_zero_n)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read one word; returns the active-high value of the driven lanes.
    task automatic rd(input logic [1:0] sel, output logic [15:0] val,
                      output logic lo, output logic hi);
        @(negedge clk);
        rd_en  = 1'b1;
        rd_sel = sel;
        #1;
        lo = drv_lo;
        hi = drv_hi;
        val = hi ? ~bus_n : (~bus_n & LO_M);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic load_len(input logic [15:0] v, input logic with_dec);
        @(negedge clk);
        data_n = ~v; len_load = 1'b1; len_dec = with_dec;
        @(negedge clk);
        len_load = 1'b0; len_dec = 1'b0; data_n = 16'hFFFF;
    endtask

    task automatic load_adr(input logic [15:0] v, input logic with_inc);
        @(negedge clk);
        data_n = ~v; adr_load = 1'b1; adr_inc = with_inc;
        @(negedge clk);
        adr_load = 1'b0; adr_inc = 1'b0; data_n = 16'hFFFF;
    endtask

    task automatic dec1();
        @(negedge clk); len_dec = 1'b1;
        @(negedge clk); len_dec = 1'b0;
    endtask

    task automatic inc1();
        @(negedge clk); adr_inc = 1'b1;
        @(negedge clk); adr_inc = 1'b0;
    endtask

    initial begin : watchdog
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        logic lo, hi;
        logic [15:0] expv;
        logic [15:0] lens [6];
        lens = '{16'h0000, 16'h0001, 16'h00FF, 16'h1000, 16'hABCD, 16'hFFFF};

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state and idle strobes
        #1;
        chk("R1 idle drv", {14'd0, drv_hi, drv_lo}, 16'd0);
        rd(2'b10, v, lo, hi); chk("R1 len reset", v, 16'h0000);
        rd(2'b01, v, lo, hi); chk("R1 adr reset", v, 16'h0000);
        chk("R5 zero after reset", {14'd0, len_zero_n, len_zero}, 16'b01);

        // R2 / R5 / R11: length loads
        foreach (lens[i]) begin
            load_len(lens[i], 1'b0);
            rd(2'b10, v, lo, hi);
            chk("R2 len load", v, lens[i]);
            chk("R11 len strobes", {14'd0, hi, lo}, 16'b11);
            chk("R5 len_zero", {14'd0, len_zero_n, len_zero},
                (lens[i] == 16'h0) ? 16'b01 : 16'b10);
        end

        // R3: borrow across all stages
        load_len(16'h1000, 1'b0);
        dec1();
        rd(2'b10, v, lo, hi); chk("R3 borrow chain", v, 16'h0FFF);
        load_len(16'h0100, 1'b0);
        dec1();
        rd(2'b10, v, lo, hi); chk("R3 borrow two stages", v, 16'h00FF);

        // R3 / R5: full countdown
        load_len(16'h0111, 1'b0);
        for (int n = 16'h0111; n > 0; n--) begin
            dec1();
            rd(2'b10, v, lo, hi);
            chk("R3 countdown", v, 16'(n - 1));
            chk("R5 countdown flag", {15'd0, len_zero}, (n == 1) ? 16'd1 : 16'd0);
        end

        // R4: decrement at zero
        dec1(); dec1();
        rd(2'b10, v, lo, hi); chk("R4 hold at zero", v, 16'h0000);
        chk("R4 flag stays", {14'd0, len_zero_n, len_zero}, 16'b01);

        // R7: load beats step
        load_len(16'h0042, 1'b1);
        rd(2'b10, v, lo, hi); chk("R7 len load priority", v, 16'h0042);
        load_adr(16'h1234, 1'b1);
        rd(2'b01, v, lo, hi); chk("R7 adr load priority", v, 16'h1234);

        // R6: address wrap and carry sweep
        load_adr(16'hFFFE, 1'b0);
        inc1();
        rd(2'b01, v, lo, hi); chk("R6 adr inc", v, 16'hFFFF);
        inc1();
        rd(2'b01, v, lo, hi); chk("R6 adr wrap", v, 16'h0000);
        load_adr(16'h0FF0, 1'b0);
        for (int n = 1; n <= 40; n++) begin
            inc1();
            rd(2'b01, v, lo, hi);
            chk("R6 adr carry sweep", v, 16'(16'h0FF0 + n));
            chk("R11 adr strobes", {14'd0, hi, lo}, 16'b11);
        end

        // R8 / R9 / R10 / R12: status and control over every flag pattern
        for (int f = 0; f < 16; f++) begin
            @(negedge clk);
            chain_flag = f[0]; abort_flag = f[1]; busabort_flag = f[2]; mode_flag = f[3];
            rd(2'b00, v, lo, hi);
            expv = 16'h0002 | (16'(f[0]) << 7) | (16'(f[1]) << 6);
            chk("R9 status word", v, expv);
            chk("R12 status strobes", {14'd0, hi, lo}, 16'b01);
            rd(2'b11, v, lo, hi);
            expv = 16'h0041 | (16'(f[2]) << 7) | (16'(f[3]) << 1);
            chk("R10 control word", v, expv);
            chk("R8 control strobes", {14'd0, hi, lo}, 16'b01);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule